// File: doc/BRIEF.md
# UART Data and Status Register Interface

This block is the processor-facing register layer of a simple serial port. It sits between a synchronous register bus and two separate engines, a transmit shifter and a receive shifter, which do the bit-level work. Two register locations are decoded. The data location is shared by two independent storage elements. A write to it fills a transmit holding buffer, and a read from it returns the most recently accepted received byte. The status location exposes the flags software polls or takes interrupts on.

Each flag has its own clearing rule. The receive-ready flag clears when the data location is read. The transmit-finished flag clears when its interrupt is acknowledged, or when software writes a one to its bit. The buffer-empty flag clears when the data location is written, and it comes out of reset already set. Three interrupt request lines follow their flags as levels, each gated by its own enable input.

The transmit shifter is offered the held byte through a request/acknowledge pair. It reports when it is idle, and it reports when a complete character, stop bit included, has left the line. The receive shifter presents each completed byte with a one-cycle valid strobe and a framing-error indication.

Top module: `uart_regif`

## Requirements
- R1: After reset, a status read returns 0x20 (only the buffer-empty bit 5 set), a data read returns 0x00, and no interrupt request is asserted.
- R2: A write to the data address (bus_addr=0) stores the byte in the holding buffer and clears status bit 5 on the following cycle. From then on, whenever tx_idle is high, tx_load_req is asserted with the held byte on tx_load_data.
- R3: tx_load_req stays low while tx_idle is low. A cycle with tx_load_req and tx_load_ack both high transfers the byte and sets status bit 5 again, which drops the request.
- R4: A data write while the holding buffer is still full replaces the held byte.
- R5: A tx_done pulse sets status bit 6 only when the holding buffer is empty (bit 5 set). It has no effect while a byte is waiting.
- R6: Status bit 6 clears on a txc_irq_ack pulse, or on a write to the status address (bus_addr=1) with data bit 6 equal to 1. Writing 0 to bit 6 leaves it unchanged.
- R7: When rx_valid is high and status bit 7 is clear, the byte on rx_data is stored and bit 7 sets, even if rx_frame_err is high. Bit 4 takes the framing-error value of the stored byte and keeps it until the next stored byte.
- R8: A data read returns the stored received byte and, on that cycle's edge, clears status bits 7 and 3.
- R9: When rx_valid arrives while bit 7 is set and no data read occurs in that cycle, the new byte is discarded and the overrun bit 3 sets.
- R10: Status bit 0 is a read/write mode bit. Bits 2 and 1 read 0. Bits 7, 5, 4 and 3 do not change on a status write.
- R11: rx_irq, txc_irq and dre_irq are high exactly while bit 7, bit 6 and bit 5 respectively are set and the matching enable input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 1 | Register select: 0 data, 1 status |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; read side effects apply on this cycle's edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| tx_idle | input | 1 | Transmit shifter can accept a byte |
| tx_load_ack | input | 1 | Transmit shifter takes the offered byte |
| tx_done | input | 1 | Pulse: last stop bit has left the shifter |
| tx_load_req | output | 1 | A held byte is offered to the shifter |
| tx_load_data | output | 8 | Byte offered to the shifter |
| rx_valid | input | 1 | Pulse: receive shifter has a complete byte |
| rx_data | input | 8 | Byte from the receive shifter |
| rx_frame_err | input | 1 | Framing error for the byte presented with rx_valid |
| rxc_irq_en | input | 1 | Enable for the receive interrupt |
| txc_irq_en | input | 1 | Enable for the transmit-finished interrupt |
| dre_irq_en | input | 1 | Enable for the buffer-empty interrupt |
| txc_irq_ack | input | 1 | Pulse: transmit-finished interrupt has been taken |
| rx_irq | output | 1 | Receive interrupt request |
| txc_irq | output | 1 | Transmit-finished interrupt request |
| dre_irq | output | 1 | Buffer-empty interrupt request |

## Verification
On every cycle, the assertions check the edge-by-edge flag rules: a data write empties the buffer-empty flag, an accepted hand-off refills it, an accepted byte sets the receive flag with the right contents, and a colliding byte sets overrun while leaving the stored byte untouched. They also check that a data read clears the receive and overrun flags and that an interrupt acknowledge clears the transmit-finished flag. The directed scenarios are needed for what appears only at the bus: the reset values, the overwrite of a still-full buffer, and tx_done being ignored while a byte waits. The same applies to the write-one-to-clear behaviour with its write-zero counterpart, the read-only and always-zero status bits, the framing-error bit persisting across a read, and the interrupt gating.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int STAT_W   = 8;
  localparam int BIT_RXC  = 7;
  localparam int BIT_TXC  = 6;
  localparam int BIT_DRE  = 5;
  localparam int BIT_FERR = 4;
  localparam int BIT_OVR  = 3;
  localparam int BIT_MODE = 0;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_idle,
  input  logic              tx_load_ack,
  input  logic              tx_done,
  input  logic              txc_clr,
  output logic              load_req,
  output logic [DATA_W-1:0] load_data,
  output logic              dre,
  output logic              txc
);
  logic [DATA_W-1:0] hold_q;
  logic              dre_q, dre_d;
  logic              txc_q, txc_d;

  assign load_req  = ~dre_q & tx_idle;
  assign load_data = hold_q;
  assign dre       = dre_q;
  assign txc       = txc_q;

  always_comb begin
    dre_d = dre_q;
    if (load_req && tx_load_ack) dre_d = 1'b1;
    if (wr_en)                   dre_d = 1'b0;
  end

  always_comb begin
    txc_d = txc_q;
    if (txc_clr)                          txc_d = 1'b0;
    if (tx_done && dre_q && !wr_en)       txc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dre_q <= 1'b1;
      txc_q <= 1'b0;
    end else begin
      dre_q <= dre_d;
      txc_q <= txc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= wr_data;
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rxc,
  output logic              ferr,
  output logic              ovr
);
  logic [DATA_W-1:0] byte_q;
  logic              rxc_q, rxc_d;
  logic              fe_q, fe_d;
  logic              ovr_q, ovr_d;
  logic              accept;

  assign accept  = rx_valid & (~rxc_q | rd_en);
  assign rx_byte = byte_q;
  assign rxc     = rxc_q;
  assign ferr    = fe_q;
  assign ovr     = ovr_q;

  always_comb begin
    rxc_d = rxc_q;
    fe_d  = fe_q;
    ovr_d = ovr_q;
    if (rd_en) begin
      rxc_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (accept) begin
      rxc_d = 1'b1;
      fe_d  = rx_frame_err;
    end else if (rx_valid) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q <= 1'b0;
      fe_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rxc_q <= rxc_d;
      fe_q  <= fe_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (accept) byte_q <= rx_data;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_idle,
  input  logic              tx_load_ack,
  input  logic              tx_done,
  output logic              tx_load_req,
  output logic [DATA_W-1:0] tx_load_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rxc_irq_en,
  input  logic              txc_irq_en,
  input  logic              dre_irq_en,
  input  logic              txc_irq_ack,
  output logic              rx_irq,
  output logic              txc_irq,
  output logic              dre_irq
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              data_wr, data_rd, stat_wr;
  logic              txc_clr;
  logic              dre_flag, txc_flag, rxc_flag, fe_flag, ovr_flag;
  logic              mode_q, mode_d;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign data_wr = bus_we & (bus_addr == ADDR_DATA);
  assign data_rd = bus_re & (bus_addr == ADDR_DATA);
  assign stat_wr = bus_we & (bus_addr == ADDR_STAT);
  assign txc_clr = txc_irq_ack | (stat_wr & bus_wdata[BIT_TXC]);

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (data_wr),
    .wr_data     (bus_wdata),
    .tx_idle     (tx_idle),
    .tx_load_ack (tx_load_ack),
    .tx_done     (tx_done),
    .txc_clr     (txc_clr),
    .load_req    (tx_load_req),
    .load_data   (tx_load_data),
    .dre         (dre_flag),
    .txc         (txc_flag)
  );

  uart_rx_buf #(.DATA_W(DATA_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rd_en        (data_rd),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .rx_byte      (rx_byte),
    .rxc          (rxc_flag),
    .ferr         (fe_flag),
    .ovr          (ovr_flag)
  );

  always_comb begin
    mode_d = mode_q;
    if (stat_wr) mode_d = bus_wdata[BIT_MODE];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= 1'b0;
    else             mode_q <= mode_d;
  end

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_RXC]  = rxc_flag;
    stat_word[BIT_TXC]  = txc_flag;
    stat_word[BIT_DRE]  = dre_flag;
    stat_word[BIT_FERR] = fe_flag;
    stat_word[BIT_OVR]  = ovr_flag;
    stat_word[BIT_MODE] = mode_q;
  end

  assign bus_rdata = (bus_addr == ADDR_DATA) ? rx_byte : stat_word;

  assign rx_irq  = rxc_flag & rxc_irq_en;
  assign txc_irq = txc_flag & txc_irq_en;
  assign dre_irq = dre_flag & dre_irq_en;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic              tx_load_req,
  input logic              tx_load_ack,
  input logic              tx_done,
  input logic              txc_irq_ack,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] rx_byte,
  input logic              dre_flag,
  input logic              txc_flag,
  input logic              rxc_flag,
  input logic              ovr_flag
);
  logic wr_d, rd_d;
  assign wr_d = bus_we & (bus_addr == ADDR_DATA);
  assign rd_d = bus_re & (bus_addr == ADDR_DATA);

  assert_write_empties_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_d |=> !dre_flag);

  assert_handoff_refills_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_load_req && tx_load_ack && !wr_d) |=> dre_flag);

  assert_ack_clears_txc_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (txc_irq_ack && !tx_done) |=> !txc_flag);

  assert_byte_stored_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && !rxc_flag) |=> (rxc_flag && rx_byte == $past(rx_data)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_d && !rx_valid) |=> (!rxc_flag && !ovr_flag));

  assert_overrun_drops_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rxc_flag && !rd_d) |=> (ovr_flag && $stable(rx_byte)));
endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .tx_load_req (tx_load_req),
  .tx_load_ack (tx_load_ack),
  .tx_done     (tx_done),
  .txc_irq_ack (txc_irq_ack),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .rx_byte     (rx_byte),
  .dre_flag    (dre_flag),
  .txc_flag    (txc_flag),
  .rxc_flag    (rxc_flag),
  .ovr_flag    (ovr_flag)
);

// File: tb/tb_uart_regif.sv
`timescale 1ns/1ps
module tb_uart_regif;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_we, bus_re;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tx_idle, tx_load_ack, tx_done, tx_load_req;
  logic [7:0] tx_load_data;
  logic       rx_valid, rx_frame_err;
  logic [7:0] rx_data;
  logic       rxc_irq_en, txc_irq_en, dre_irq_en, txc_irq_ack;
  logic       rx_irq, txc_irq, dre_irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  uart_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_idle(tx_idle),
    .tx_load_ack(tx_load_ack), .tx_done(tx_done), .tx_load_req(tx_load_req),
    .tx_load_data(tx_load_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rxc_irq_en(rxc_irq_en), .txc_irq_en(txc_irq_en),
    .dre_irq_en(dre_irq_en), .txc_irq_ack(txc_irq_ack), .rx_irq(rx_irq),
    .txc_irq(txc_irq), .dre_irq(dre_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(posedge clk); #1 tx_done = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] d, input logic fe);
    @(negedge clk); rx_data = d; rx_frame_err = fe; rx_valid = 1'b1;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic handoff();
    @(negedge clk); tx_idle = 1'b1; tx_load_ack = 1'b1;
    @(posedge clk); #1 tx_load_ack = 1'b0; tx_idle = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rxc_irq_en = 1'b1; txc_irq_en = 1'b1; dre_irq_en = 1'b0;
    bus_read(1'b1, v); check("R1 status", v, 8'h20);
    bus_read(1'b0, v); check("R1 data", v, 8'h00);
    check("R1 irqs", {5'd0, rx_irq, txc_irq, dre_irq}, 8'h00);
    rxc_irq_en = 1'b0; txc_irq_en = 1'b0;
  endtask

  task automatic t_transmit();
    logic [7:0] v;
    dre_irq_en = 1'b1;
    @(negedge clk); check("R11 dre_irq on", {7'd0, dre_irq}, 8'h01);
    bus_write(1'b0, 8'hA5);
    bus_read(1'b1, v); check("R2 dre clear", v, 8'h00);
    check("R11 dre_irq off", {7'd0, dre_irq}, 8'h00);
    check("R3 no req while busy", {7'd0, tx_load_req}, 8'h00);
    bus_write(1'b0, 8'h3C);
    @(negedge clk); tx_idle = 1'b1;
    #1 check("R2 req", {7'd0, tx_load_req}, 8'h01);
    check("R4 overwrite", tx_load_data, 8'h3C);
    tx_idle = 1'b0;
    handoff();
    bus_read(1'b1, v); check("R3 dre set", v, 8'h20);
    tx_idle = 1'b1;
    #1 check("R3 req dropped", {7'd0, tx_load_req}, 8'h00);
    tx_idle = 1'b0;
    dre_irq_en = 1'b0;
  endtask

  task automatic t_tx_complete();
    logic [7:0] v;
    txc_irq_en = 1'b1;
    pulse_done();
    bus_read(1'b1, v); check("R5 txc set", v, 8'h60);
    check("R11 txc_irq", {7'd0, txc_irq}, 8'h01);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, v); check("R6 write0 keeps", v, 8'h60);
    bus_write(1'b1, 8'h40);
    bus_read(1'b1, v); check("R6 write1 clears", v, 8'h20);
    pulse_done();
    @(negedge clk); txc_irq_ack = 1'b1;
    @(posedge clk); #1 txc_irq_ack = 1'b0;
    bus_read(1'b1, v); check("R6 ack clears", v, 8'h20);
    bus_write(1'b0, 8'h77);
    pulse_done();
    bus_read(1'b1, v); check("R5 done ignored when full", v, 8'h00);
    handoff();
    txc_irq_en = 1'b0;
  endtask

  task automatic t_receive();
    logic [7:0] v;
    rxc_irq_en = 1'b1;
    pulse_rx(8'h5A, 1'b1);
    bus_read(1'b1, v); check("R7 rxc+fe", v, 8'hB0);
    check("R11 rx_irq", {7'd0, rx_irq}, 8'h01);
    bus_read(1'b0, v); check("R8 data", v, 8'h5A);
    bus_read(1'b1, v); check("R8 rxc cleared", v, 8'h30);
    pulse_rx(8'h11, 1'b0);
    bus_read(1'b1, v); check("R7 fe follows", v, 8'hA0);
    pulse_rx(8'h22, 1'b0);
    bus_read(1'b1, v); check("R9 overrun", v, 8'hA8);
    bus_read(1'b0, v); check("R9 dropped", v, 8'h11);
    bus_read(1'b1, v); check("R8 ovr cleared", v, 8'h20);
    check("R11 rx_irq off", {7'd0, rx_irq}, 8'h00);
    rxc_irq_en = 1'b0;
  endtask

  task automatic t_mode_bits();
    logic [7:0] v;
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, v); check("R10 mode set, ro ignored", v, 8'h21);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, v); check("R10 mode clear", v, 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    tx_idle = 1'b0; tx_load_ack = 1'b0; tx_done = 1'b0;
    rx_valid = 1'b0; rx_data = '0; rx_frame_err = 1'b0;
    rxc_irq_en = 1'b0; txc_irq_en = 1'b0; dre_irq_en = 1'b0; txc_irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_transmit();
    t_tx_complete();
    t_receive();
    t_mode_bits();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL all watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule